// File: doc/BRIEF.md
# Banked Register Switch Unit

This unit holds a general register file in which one window of register numbers is duplicated into two banks. Every register, shared or banked, stores a data value together with a deferred-exception flag (a "not a thing" marker), and the flag of a banked register lives in the same bank as its data. A single current-bank bit decides which copy of the banked window is visible to the read and write ports. Register numbers outside the window always reach one shared array.

The bank bit changes on three events. Interrupt entry saves the current bank bit into a saved-status bit and then selects bank 0, so handlers get a private set of scratch registers without spilling anything. Interrupt return restores the bank from that saved bit. An explicit switch command selects the bank named by its operand. A bank change affects register accesses from the following cycle. The read port is combinational on the stored state, and writes land at the clock edge.

Top module: `bankreg_unit`

## Requirements
- R1: After reset the current bank bit and the saved bit are 0, and every register reads back data 0 with its deferred-exception flag 0.
- R2: Register numbers below 16 and from 32 to NUM_REGS-1 (47 by default) reach one shared storage, and the same value reads back whichever bank is selected.
- R3: An interrupt-entry pulse makes the current bank bit 0 in the following cycle.
- R4: An interrupt-entry pulse copies the current bank bit, as it was before the event, into the saved bit.
- R5: An interrupt-return pulse without interrupt entry loads the current bank bit from the saved bit, and leaves the saved bit unchanged.
- R6: A switch command without interrupt entry or return loads the current bank bit from its one-bit operand.
- R7: When events coincide, interrupt entry wins over interrupt return, and interrupt return wins over the switch command.
- R8: Register numbers 16 to 31 reach the bank named by the current bank bit (0 or 1), and both the data value and the deferred-exception flag are kept separately per bank.
- R9: A read or write in the same cycle as a bank-changing event uses the bank that was selected before the event.
- R10: A write with write enable high stores data and flag, and the stored pair is visible on the read port from the next cycle on.
- R11: A write to a register number at or above NUM_REGS changes no register, and a read of such a number returns data 0 and flag 0.
- R12: With no event pending, the current bank bit and the saved bit hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| intr_enter | input | 1 | Interrupt-entry event pulse |
| intr_return | input | 1 | Return-from-interrupt event pulse |
| sw_req | input | 1 | Explicit bank-switch command |
| sw_bank | input | 1 | Bank selected by the switch command |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | IDX_W (6) | Register number written |
| wr_data | input | DATA_W (32) | Write data value |
| wr_nat | input | 1 | Write deferred-exception flag |
| rd_idx | input | IDX_W (6) | Register number read |
| rd_data | output | DATA_W (32) | Read data value |
| rd_nat | output | 1 | Read deferred-exception flag |
| cur_bank | output | 1 | Current bank bit |
| saved_bank | output | 1 | Bank bit saved at interrupt entry |

## Verification
The assertions take the event inputs, register numbers and write data to be known (not X) in every cycle after reset, and the shared-read property assumes no write is issued in a cycle it checks. The bench drives every input on the falling edge and keeps them all defined from before reset release. It sweeps every register number in the index space through both banks, and it also drives every combination of coincident events. Event pairs that real hardware would never raise together, such as entry and return in one cycle, are still driven so that the priority order is checked.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_ENTER  = 2'd1,
        EV_RETURN = 2'd2,
        EV_SWITCH = 2'd3
    } bank_event_e;

    typedef struct packed {
        logic bank;
        logic saved;
    } bank_state_t;

endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
    import bankreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic intr_enter,
    input  logic intr_return,
    input  logic sw_req,
    input  logic sw_bank,
    output logic cur_bank,
    output logic saved_bank
);

    bank_event_e ev;
    bank_state_t st_d, st_q;

    always_comb begin
        if (intr_enter)       ev = EV_ENTER;
        else if (intr_return) ev = EV_RETURN;
        else if (sw_req)      ev = EV_SWITCH;
        else                  ev = EV_NONE;

        st_d = st_q;
        case (ev)
            EV_ENTER: begin
                st_d.saved = st_q.bank;
                st_d.bank  = 1'b0;
            end
            EV_RETURN: st_d.bank = st_q.saved;
            EV_SWITCH: st_d.bank = sw_bank;
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_bank   = st_q.bank;
    assign saved_bank = st_q.saved;

    // R3
    enter_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_enter |=> !cur_bank);

    // R4
    enter_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_enter |=> saved_bank == $past(cur_bank));

    // R5
    return_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_return && !intr_enter) |=> (cur_bank == $past(saved_bank)) && $stable(saved_bank));

    // R6
    switch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !intr_enter && !intr_return) |=> cur_bank == $past(sw_bank));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_req && !intr_enter && !intr_return) |=> $stable(cur_bank) && $stable(saved_bank));

endmodule

// File: rtl/reg_array.sv
module reg_array #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wnat,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rnat
);

    logic [DATA_W-1:0] data_d [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  nat_d, nat_q;

    always_comb begin
        data_d = data_q;
        nat_d  = nat_q;
        if (we) begin
            data_d[waddr] = wdata;
            nat_d[waddr]  = wnat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) data_q[i] <= '0;
            nat_q <= '0;
        end else begin
            data_q <= data_d;
            nat_q  <= nat_d;
        end
    end

    assign rdata = data_q[raddr];
    assign rnat  = nat_q[raddr];

    // R10
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (data_q[$past(waddr)] == $past(wdata)) && (nat_q[$past(waddr)] == $past(wnat)));

endmodule

// File: rtl/bankreg_unit.sv
module bankreg_unit #(
    parameter int NUM_REGS = 48,
    parameter int DATA_W   = 32,
    parameter int BANK_LO  = 16,
    parameter int BANK_CNT = 16,
    localparam int IDX_W   = $clog2(NUM_REGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              intr_enter,
    input  logic              intr_return,
    input  logic              sw_req,
    input  logic              sw_bank,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_nat,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_nat,
    output logic              cur_bank,
    output logic              saved_bank
);

    localparam int SH_DEPTH = NUM_REGS - BANK_CNT;
    localparam int SH_AW    = $clog2(SH_DEPTH);
    localparam int BK_AW    = $clog2(BANK_CNT);
    localparam logic [IDX_W-1:0] LO_IDX  = IDX_W'(BANK_LO);
    localparam logic [IDX_W-1:0] HI_IDX  = IDX_W'(BANK_LO + BANK_CNT - 1);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_REGS - 1);
    localparam logic [IDX_W-1:0] CNT_IDX = IDX_W'(BANK_CNT);

    function automatic logic is_banked(input logic [IDX_W-1:0] idx);
        return (idx >= LO_IDX) && (idx <= HI_IDX);
    endfunction

    function automatic logic [SH_AW-1:0] sh_map(input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] t;
        t = (idx < LO_IDX) ? idx : idx - CNT_IDX;
        return t[SH_AW-1:0];
    endfunction

    function automatic logic [BK_AW-1:0] bk_map(input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] t;
        t = idx - LO_IDX;
        return t[BK_AW-1:0];
    endfunction

    logic w_ok, w_bank, r_ok, r_bank;
    logic sh_we;
    logic [DATA_W-1:0] sh_rdata;
    logic              sh_rnat;
    logic [DATA_W-1:0] bk_rdata [2];
    logic              bk_rnat  [2];

    bank_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .intr_enter  (intr_enter),
        .intr_return (intr_return),
        .sw_req      (sw_req),
        .sw_bank     (sw_bank),
        .cur_bank    (cur_bank),
        .saved_bank  (saved_bank)
    );

    always_comb begin
        w_ok   = wr_idx <= TOP_IDX;
        w_bank = is_banked(wr_idx);
        r_ok   = rd_idx <= TOP_IDX;
        r_bank = is_banked(rd_idx);
        sh_we  = wr_en && w_ok && !w_bank;
    end

    reg_array #(.DEPTH(SH_DEPTH), .DATA_W(DATA_W)) u_shared (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sh_we),
        .waddr (sh_map(wr_idx)),
        .wdata (wr_data),
        .wnat  (wr_nat),
        .raddr (sh_map(rd_idx)),
        .rdata (sh_rdata),
        .rnat  (sh_rnat)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic bk_we;
        assign bk_we = wr_en && w_bank && (cur_bank == 1'(b));
        reg_array #(.DEPTH(BANK_CNT), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bk_we),
            .waddr (bk_map(wr_idx)),
            .wdata (wr_data),
            .wnat  (wr_nat),
            .raddr (bk_map(rd_idx)),
            .rdata (bk_rdata[b]),
            .rnat  (bk_rnat[b])
        );
    end

    always_comb begin
        if (!r_ok) begin
            rd_data = '0;
            rd_nat  = 1'b0;
        end else if (r_bank) begin
            rd_data = bk_rdata[cur_bank];
            rd_nat  = bk_rnat[cur_bank];
        end else begin
            rd_data = sh_rdata;
            rd_nat  = sh_rnat;
        end
    end

    // R2
    shared_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && r_ok && !r_bank) |=> ($stable(rd_idx) -> ($stable(rd_data) && $stable(rd_nat))));

endmodule

// File: tb/bankreg_unit_tb.sv
module bankreg_unit_tb;

    localparam int N  = 48;
    localparam int DW = 32;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic intr_enter = 0, intr_return = 0, sw_req = 0, sw_bank = 0;
    logic wr_en = 0, wr_nat = 0;
    logic [IW-1:0] wr_idx = '0, rd_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic rd_nat, cur_bank, saved_bank;

    int total = 0, bad = 0;
    logic done = 0;

    logic [DW-1:0] m_sh  [64];
    logic          m_shn [64];
    logic [DW-1:0] m_bk  [2][16];
    logic          m_bkn [2][16];
    logic m_cur = 0, m_saved = 0;

    always #5 clk = ~clk;

    bankreg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .intr_enter(intr_enter), .intr_return(intr_return),
        .sw_req(sw_req), .sw_bank(sw_bank), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_nat(wr_nat), .rd_idx(rd_idx), .rd_data(rd_data),
        .rd_nat(rd_nat), .cur_bank(cur_bank), .saved_bank(saved_bank)
    );

    task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW:0] model_rd(input int idx);
        if (idx >= N) return '0;
        if (idx >= 16 && idx < 32) return {m_bkn[m_cur][idx-16], m_bk[m_cur][idx-16]};
        return {m_shn[idx], m_sh[idx]};
    endfunction

    // read check at current state; caller is after a falling edge
    task automatic read_chk(input string req, input int idx);
        rd_idx = IW'(idx);
        #1;
        check(req, {rd_nat, rd_data}, model_rd(idx));
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            read_chk(req, i);
        end
    endtask

    task automatic bank_chk(input string req);
        total++;
        if (cur_bank !== m_cur || saved_bank !== m_saved) begin
            bad++;
            $display("FAIL %s actual=%b/%b expected=%b/%b", req, cur_bank, saved_bank, m_cur, m_saved);
        end
    endtask

    // one cycle: drive events and a write, check a read against the old bank, then update model
    task automatic step(input logic ie, input logic ir, input logic sr, input logic sb,
                        input logic we, input int widx, input logic [DW-1:0] wd,
                        input logic wn, input int ridx, input string req);
        @(negedge clk);
        intr_enter = ie; intr_return = ir; sw_req = sr; sw_bank = sb;
        wr_en = we; wr_idx = IW'(widx); wr_data = wd; wr_nat = wn;
        read_chk(req, ridx);
        @(posedge clk);
        if (we && widx < N) begin
            if (widx >= 16 && widx < 32) begin
                m_bk[m_cur][widx-16] = wd; m_bkn[m_cur][widx-16] = wn;
            end else begin
                m_sh[widx] = wd; m_shn[widx] = wn;
            end
        end
        if (ie) begin m_saved = m_cur; m_cur = 0; end
        else if (ir) m_cur = m_saved;
        else if (sr) m_cur = sb;
        @(negedge clk);
        intr_enter = 0; intr_return = 0; sw_req = 0; wr_en = 0;
        #1;
        bank_chk(req);
    endtask

    function automatic logic [DW-1:0] pat(input int i, input int b, input int ph);
        return {8'(i), 8'(b), 8'(ph), 8'hA5 ^ 8'(i * 7)};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin m_sh[i] = '0; m_shn[i] = 0; end
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 16; i++) begin m_bk[b][i] = '0; m_bkn[b][i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        bank_chk("R1");
        read_all("R1");

        // bank 0: write every number including out-of-range ones
        for (int i = 0; i < 64; i++)
            step(0, 0, 0, 0, 1, i, pat(i, 0, 1), 1'(i), i, "R10");
        read_all("R10");
        read_all("R11");

        // switch to bank 1; same-cycle read of 20 sees bank 0
        step(0, 0, 1, 1, 0, 0, '0, 0, 20, "R9");
        bank_chk("R6");
        read_all("R2");
        for (int i = 16; i < 32; i++)
            step(0, 0, 0, 0, 1, i, pat(i, 1, 2), 1'(~i), i, "R8");
        read_all("R8");
        step(0, 0, 1, 0, 0, 0, '0, 0, 25, "R9");
        read_all("R8");

        // all event combinations from both starting banks
        for (int start = 0; start < 2; start++)
            for (int code = 0; code < 16; code++) begin
                step(0, 0, 1, 1'(start), 0, 0, '0, 0, 18, "R6");
                step(code[0], code[1], code[2], code[3], 0, 0, '0, 0, 18, "R7");
                @(negedge clk);
                read_chk("R8", 18);
            end
        step(1, 0, 0, 0, 0, 0, '0, 0, 3, "R3");
        step(0, 1, 0, 0, 0, 0, '0, 0, 3, "R5");
        step(0, 0, 0, 0, 0, 0, '0, 0, 3, "R12");

        // write in the cycle of a switch lands in the old bank
        step(0, 0, 1, 0, 0, 0, '0, 0, 0, "R6");
        step(0, 0, 1, 1, 1, 17, 32'hDEAD_0017, 1, 17, "R9");
        read_all("R9");
        step(1, 0, 0, 0, 1, 30, 32'hBEEF_0030, 0, 30, "R9");
        read_all("R4");
        step(0, 1, 0, 0, 1, 40, 32'h1234_0040, 1, 30, "R5");
        read_all("R2");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule